// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a small processor that completes one instruction in every clock cycle. It runs a subset of a 32-bit load/store instruction set: register-to-register add, subtract, AND, OR and signed set-less-than, add-immediate, word load and store, and branch-if-equal and branch-if-not-equal. The core contains the program counter, an instruction store, a 32-entry register file, the immediate sign extender, the ALU, a data store and three steering multiplexers. A main decoder sets those multiplexers from the opcode and function fields: one picks the destination register, one picks the second ALU operand and one picks the writeback source.

Both memories are internal word-addressed arrays. The environment fills them through a preload port, normally while reset is held. A debug port shows the program counter of the instruction now executing and the register write it will commit at the next rising edge. An external model can therefore follow execution one instruction at a time.

There is no multi-cycle control, so there are no states or transitions to name. The only sequencing is the reset-or-advance rule of the program counter.

Top module: `scp_core`

## Requirements
- R1: An active-high synchronous reset sets the program counter to 0 and holds the register write enable low. A reset asserted during execution also returns the program counter to 0.
- R2: Any instruction that is not a taken branch advances the program counter by 4 in one clock cycle.
- R3: R-format instructions (opcode 000000) write rd = Inst[15:11] with rs op rt. The op is chosen by funct: 100000 add, 100010 sub, 100100 and, 100101 or.
- R4: addi (opcode 001000) writes rt = Inst[20:16] with rs plus the 16-bit immediate Inst[15:0] sign-extended to 32 bits.
- R5: lw (opcode 100011) writes rt with the data word at byte address rs + sign-extended offset. Address bits [1:0] are ignored.
- R6: sw (opcode 101011) stores the rt value at byte address rs + sign-extended offset, with bits [1:0] ignored. It writes no register.
- R7: beq (opcode 000100) writes no register. When rs equals rt, it jumps to PC+4 + (sign-extended offset × 4).
- R8: bne (opcode 000101) writes no register. When rs differs from rt, it jumps to PC+4 + (sign-extended offset × 4).
- R9: Register 0 always reads as zero. A write addressed to it is reported on the debug port but has no effect.
- R10: Data memory is never read and written in the same cycle.
- R11: slt (opcode 000000, funct 101010) writes 1 to rd when rs is less than rt as signed values, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Preload write strobe |
| ld_imem | input | 1 | Preload target: 1 selects the instruction store, 0 the data store |
| ld_addr | input | MEM_AW | Preload word index |
| ld_data | input | XLEN | Preload word |
| dbg_pc | output | XLEN | Program counter of the instruction now executing |
| dbg_wr_en | output | 1 | Register write requested this cycle |
| dbg_wr_addr | output | 5 | Destination register number |
| dbg_wr_data | output | XLEN | Value to be written |

## Verification
Every instruction starts and finishes within one cycle, so a wrong decode or a wrong operand shows up on the debug write port in the same cycle as the faulty instruction. A wrong program counter shows on dbg_pc one cycle after the branch or step that produced it. A corrupted register or memory word stays hidden until a later instruction reads it. For that reason the program reloads stored words, reads back register 0, and mixes signed and unsigned operand patterns, so that each such fault reaches a debug write within a few instructions.

// File: rtl/scp_pkg.sv
package scp_pkg;
    localparam int REG_AW = 5;
    localparam int NREG   = 1 << REG_AW;

    localparam logic [5:0] OP_RTYPE = 6'b000000;
    localparam logic [5:0] OP_ADDI  = 6'b001000;
    localparam logic [5:0] OP_LW    = 6'b100011;
    localparam logic [5:0] OP_SW    = 6'b101011;
    localparam logic [5:0] OP_BEQ   = 6'b000100;
    localparam logic [5:0] OP_BNE   = 6'b000101;

    localparam logic [5:0] FN_ADD = 6'b100000;
    localparam logic [5:0] FN_SUB = 6'b100010;
    localparam logic [5:0] FN_AND = 6'b100100;
    localparam logic [5:0] FN_OR  = 6'b100101;
    localparam logic [5:0] FN_SLT = 6'b101010;

    typedef enum logic [3:0] {
        ALU_AND = 4'b0000,
        ALU_OR  = 4'b0001,
        ALU_ADD = 4'b0010,
        ALU_SUB = 4'b0110,
        ALU_SLT = 4'b0111
    } alu_op_e;

    typedef struct packed {
        logic    reg_write;
        logic    dst_is_rd;
        logic    opb_is_imm;
        logic    wb_from_mem;
        logic    mem_read;
        logic    mem_write;
        logic    br_eq;
        logic    br_ne;
        alu_op_e alu_op;
    } ctrl_t;
endpackage

// File: rtl/scp_decoder.sv
module scp_decoder
    import scp_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctrl_t      ctl
);
    always_comb begin
        ctl = '0;
        ctl.alu_op = ALU_ADD;
        unique case (opcode)
            OP_RTYPE: begin
                ctl.dst_is_rd = 1'b1;
                ctl.reg_write = 1'b1;
                unique case (funct)
                    FN_ADD:  ctl.alu_op = ALU_ADD;
                    FN_SUB:  ctl.alu_op = ALU_SUB;
                    FN_AND:  ctl.alu_op = ALU_AND;
                    FN_OR:   ctl.alu_op = ALU_OR;
                    FN_SLT:  ctl.alu_op = ALU_SLT;
                    default: ctl.reg_write = 1'b0;
                endcase
            end
            OP_ADDI: begin
                ctl.reg_write  = 1'b1;
                ctl.opb_is_imm = 1'b1;
            end
            OP_LW: begin
                ctl.reg_write   = 1'b1;
                ctl.opb_is_imm  = 1'b1;
                ctl.wb_from_mem = 1'b1;
                ctl.mem_read    = 1'b1;
            end
            OP_SW: begin
                ctl.opb_is_imm = 1'b1;
                ctl.mem_write  = 1'b1;
            end
            OP_BEQ: begin
                ctl.alu_op = ALU_SUB;
                ctl.br_eq  = 1'b1;
            end
            OP_BNE: begin
                ctl.alu_op = ALU_SUB;
                ctl.br_ne  = 1'b1;
            end
            default: ctl = '0;
        endcase
    end
endmodule

// File: rtl/scp_alu.sv
module scp_alu
    import scp_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    input  alu_op_e         op,
    output logic [XLEN-1:0] res,
    output logic            is_zero
);
    always_comb begin
        unique case (op)
            ALU_AND: res = opa & opb;
            ALU_OR:  res = opa | opb;
            ALU_ADD: res = opa + opb;
            ALU_SUB: res = opa - opb;
            ALU_SLT: res = {{(XLEN-1){1'b0}}, ($signed(opa) < $signed(opb))};
            default: res = '0;
        endcase
    end
    assign is_zero = (res == '0);
endmodule

// File: rtl/scp_regfile.sv
module scp_regfile
    import scp_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic              clk,
    input  logic [REG_AW-1:0] ra1,
    input  logic [REG_AW-1:0] ra2,
    output logic [XLEN-1:0]   rd1,
    output logic [XLEN-1:0]   rd2,
    input  logic              we,
    input  logic [REG_AW-1:0] wa,
    input  logic [XLEN-1:0]   wd
);
    logic [XLEN-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (we && (wa != '0)) regs[wa] <= wd;
    end

    assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
    assign rd2 = (ra2 == '0) ? '0 : regs[ra2];
endmodule

// File: rtl/scp_core.sv
module scp_core
    import scp_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int MEM_AW = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_en,
    input  logic              ld_imem,
    input  logic [MEM_AW-1:0] ld_addr,
    input  logic [XLEN-1:0]   ld_data,
    output logic [XLEN-1:0]   dbg_pc,
    output logic              dbg_wr_en,
    output logic [REG_AW-1:0] dbg_wr_addr,
    output logic [XLEN-1:0]   dbg_wr_data
);
    localparam int MEM_DEPTH = 1 << MEM_AW;
    localparam int IMM_W     = 16;

    logic [XLEN-1:0] pc_q, pc_plus4, br_target, pc_next;
    logic [XLEN-1:0] instr, imm_ext, rd1, rd2, opb, alu_res, mem_rdata, wb_data;
    logic [XLEN-1:0] imem [MEM_DEPTH];
    logic [XLEN-1:0] dmem [MEM_DEPTH];
    logic [5:0]        opcode, funct;
    logic [REG_AW-1:0] rs, rt, rd, wa;
    logic              alu_zero, take_br, reg_we;
    ctrl_t             ctl;

    // Instruction fetch, word addressed
    assign instr = imem[pc_q[MEM_AW+1:2]];

    assign opcode  = instr[31:26];
    assign rs      = instr[25:21];
    assign rt      = instr[20:16];
    assign rd      = instr[15:11];
    assign funct   = instr[5:0];
    assign imm_ext = {{(XLEN-IMM_W){instr[IMM_W-1]}}, instr[IMM_W-1:0]};

    scp_decoder dec_i (.opcode(opcode), .funct(funct), .ctl(ctl));

    scp_regfile #(.XLEN(XLEN)) rf_i (
        .clk(clk), .ra1(rs), .ra2(rt), .rd1(rd1), .rd2(rd2),
        .we(reg_we), .wa(wa), .wd(wb_data)
    );

    // Steering: destination, second operand, writeback source
    assign wa  = ctl.dst_is_rd  ? rd      : rt;
    assign opb = ctl.opb_is_imm ? imm_ext : rd2;

    scp_alu #(.XLEN(XLEN)) alu_i (
        .opa(rd1), .opb(opb), .op(ctl.alu_op), .res(alu_res), .is_zero(alu_zero)
    );

    assign mem_rdata = dmem[alu_res[MEM_AW+1:2]];
    assign wb_data   = ctl.wb_from_mem ? mem_rdata : alu_res;
    assign reg_we    = ctl.reg_write & ~rst;

    always_ff @(posedge clk) begin
        if (ld_en && ld_imem) imem[ld_addr] <= ld_data;
    end

    always_ff @(posedge clk) begin
        if (ld_en && !ld_imem)
            dmem[ld_addr] <= ld_data;
        else if (!rst && ctl.mem_write)
            dmem[alu_res[MEM_AW+1:2]] <= rd2;
    end

    // Next PC
    assign pc_plus4  = pc_q + XLEN'(4);
    assign br_target = pc_plus4 + (imm_ext << 2);
    assign take_br   = (ctl.br_eq & alu_zero) | (ctl.br_ne & ~alu_zero);
    assign pc_next   = take_br ? br_target : pc_plus4;

    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_next;
    end

    assign dbg_pc      = pc_q;
    assign dbg_wr_en   = reg_we;
    assign dbg_wr_addr = wa;
    assign dbg_wr_data = wb_data;

    logic unused_bits;
    assign unused_bits = ^{instr[10:6], alu_res, ctl.mem_read};
endmodule

// File: rtl/scp_core_chk.sv
module scp_core_chk
    import scp_pkg::*;
#(
    parameter int XLEN = 32
) (
    input logic              clk,
    input logic              rst,
    input logic [XLEN-1:0]   pc,
    input logic [XLEN-1:0]   target,
    input logic              take_br,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic [5:0]        opcode,
    input logic [REG_AW-1:0] rs,
    input logic [XLEN-1:0]   rd1,
    input logic              wr_en
);
    // R1
    a_r1_pc_reset: assert property (@(posedge clk) rst |=> pc == '0);
    // R2
    a_r2_pc_step: assert property (@(posedge clk) disable iff (rst)
        !take_br |=> pc == $past(pc) + XLEN'(4));
    // R7 R8
    a_r7_branch_target: assert property (@(posedge clk) disable iff (rst)
        take_br |=> pc == $past(target));
    // R10
    a_r10_mem_excl: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));
    // R9
    a_r9_zero_reg: assert property (@(posedge clk) disable iff (rst)
        (rs == '0) |-> rd1 == '0);
    // R6
    a_r6_store_nowrite: assert property (@(posedge clk) disable iff (rst)
        (opcode == OP_SW || opcode == OP_BEQ || opcode == OP_BNE) |-> !wr_en);
endmodule

bind scp_core scp_core_chk #(.XLEN(XLEN)) chk_i (
    .clk(clk), .rst(rst), .pc(pc_q), .target(br_target), .take_br(take_br),
    .mem_rd(ctl.mem_read), .mem_wr(ctl.mem_write), .opcode(opcode),
    .rs(rs), .rd1(rd1), .wr_en(dbg_wr_en)
);

// File: tb/scp_core_tb.sv
module scp_core_tb_top;
    localparam int CLK_P  = 10;
    localparam int XLEN   = 32;
    localparam int MEM_AW = 6;
    localparam int NPROG  = 22;
    localparam int NSTEP  = 19;

    function automatic logic [31:0] enc_r(input logic [5:0] fn, input int s, input int t, input int d);
        return {6'b000000, 5'(s), 5'(t), 5'(d), 5'd0, fn};
    endfunction
    function automatic logic [31:0] enc_i(input logic [5:0] op, input int s, input int t, input int imm);
        return {op, 5'(s), 5'(t), 16'(imm)};
    endfunction

    localparam logic [5:0] ADDI = 6'b001000, LW = 6'b100011, SW = 6'b101011;
    localparam logic [5:0] BEQ = 6'b000100, BNE = 6'b000101;
    localparam logic [5:0] FADD = 6'b100000, FSUB = 6'b100010, FAND = 6'b100100;
    localparam logic [5:0] FOR = 6'b100101, FSLT = 6'b101010;

    localparam logic [31:0] PROG [NPROG] = '{
        enc_i(ADDI, 0, 1, 5),        // 0
        enc_i(ADDI, 0, 2, -3),       // 4
        enc_r(FADD, 1, 2, 3),        // 8
        enc_r(FSUB, 1, 2, 4),        // 12
        enc_r(FAND, 1, 2, 5),        // 16
        enc_r(FOR,  1, 2, 6),        // 20
        enc_r(FSLT, 2, 1, 7),        // 24
        enc_r(FSLT, 1, 2, 8),        // 28
        enc_i(SW,   0, 1, 8),        // 32
        enc_i(SW,   4, 2, -4),       // 36
        enc_i(LW,   0, 9, 9),        // 40
        enc_i(LW,   0, 10, 4),       // 44
        enc_i(ADDI, 1, 0, 7),        // 48
        enc_r(FADD, 0, 0, 11),       // 52
        enc_i(BEQ,  1, 3, 2),        // 56
        enc_i(BNE,  1, 3, 2),        // 60
        enc_i(ADDI, 0, 12, 1),       // 64
        enc_i(ADDI, 0, 12, 2),       // 68
        enc_i(BEQ,  9, 1, 1),        // 72
        enc_i(ADDI, 0, 13, 9),       // 76
        enc_i(BNE,  1, 1, 5),        // 80
        enc_i(ADDI, 0, 13, -1)       // 84
    };

    typedef struct packed {
        logic [31:0] pc;
        logic        we;
        logic [4:0]  wa;
        logic [31:0] wd;
        logic [3:0]  req;
    } row_t;

    localparam row_t EXP [NSTEP] = '{
        '{32'd0,  1'b1, 5'd1,  32'd5,        4'd4},   // R4
        '{32'd4,  1'b1, 5'd2,  32'hFFFFFFFD, 4'd4},   // R4 sign extension
        '{32'd8,  1'b1, 5'd3,  32'd2,        4'd3},   // R3 add
        '{32'd12, 1'b1, 5'd4,  32'd8,        4'd3},   // R3 sub
        '{32'd16, 1'b1, 5'd5,  32'd5,        4'd3},   // R3 and
        '{32'd20, 1'b1, 5'd6,  32'hFFFFFFFD, 4'd3},   // R3 or
        '{32'd24, 1'b1, 5'd7,  32'd1,        4'd11},  // R11 signed less
        '{32'd28, 1'b1, 5'd8,  32'd0,        4'd11},  // R11
        '{32'd32, 1'b0, 5'd0,  32'd0,        4'd6},   // R6
        '{32'd36, 1'b0, 5'd0,  32'd0,        4'd6},   // R6 negative offset
        '{32'd40, 1'b1, 5'd9,  32'd5,        4'd5},   // R5 low bits ignored
        '{32'd44, 1'b1, 5'd10, 32'hFFFFFFFD, 4'd5},   // R5
        '{32'd48, 1'b1, 5'd0,  32'd12,       4'd9},   // R9 write to r0
        '{32'd52, 1'b1, 5'd11, 32'd0,        4'd9},   // R9 r0 still zero
        '{32'd56, 1'b0, 5'd0,  32'd0,        4'd7},   // R7 not taken
        '{32'd60, 1'b0, 5'd0,  32'd0,        4'd8},   // R8 taken
        '{32'd72, 1'b0, 5'd0,  32'd0,        4'd7},   // R7 taken
        '{32'd80, 1'b0, 5'd0,  32'd0,        4'd8},   // R8 not taken
        '{32'd84, 1'b1, 5'd13, 32'hFFFFFFFF, 4'd2}    // R2
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              ld_en = 1'b0;
    logic              ld_imem = 1'b0;
    logic [MEM_AW-1:0] ld_addr = '0;
    logic [XLEN-1:0]   ld_data = '0;
    logic [XLEN-1:0]   dbg_pc;
    logic              dbg_wr_en;
    logic [4:0]        dbg_wr_addr;
    logic [XLEN-1:0]   dbg_wr_data;

    int checks = 0;
    int failures = 0;

    always #(CLK_P/2) clk = ~clk;

    scp_core #(.XLEN(XLEN), .MEM_AW(MEM_AW)) dut_i (
        .clk(clk), .rst(rst), .ld_en(ld_en), .ld_imem(ld_imem),
        .ld_addr(ld_addr), .ld_data(ld_data), .dbg_pc(dbg_pc),
        .dbg_wr_en(dbg_wr_en), .dbg_wr_addr(dbg_wr_addr), .dbg_wr_data(dbg_wr_data)
    );

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic load(input logic to_imem, input int idx, input logic [31:0] w);
        @(negedge clk);
        ld_en = 1'b1; ld_imem = to_imem; ld_addr = MEM_AW'(idx); ld_data = w;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    initial begin
        #(CLK_P * 5000);
        failures++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < (1 << MEM_AW); i++) begin
            load(1'b1, i, (i < NPROG) ? PROG[i] : 32'd0);
            load(1'b0, i, 32'd0);
        end
        @(negedge clk);
        chk(dbg_pc == 0, "R1 reset pc", dbg_pc, 0);
        chk(dbg_wr_en == 1'b0, "R1 reset write enable", 32'(dbg_wr_en), 0);
        rst = 1'b0;
        #1;
        for (int k = 0; k < NSTEP; k++) begin
            string tag;
            tag = $sformatf("R%0d step %0d", EXP[k].req, k);
            chk(dbg_pc == EXP[k].pc, {tag, " pc"}, dbg_pc, EXP[k].pc);
            chk(dbg_wr_en == EXP[k].we, {tag, " we"}, 32'(dbg_wr_en), 32'(EXP[k].we));
            if (EXP[k].we) begin
                chk(dbg_wr_addr == EXP[k].wa, {tag, " waddr"}, 32'(dbg_wr_addr), 32'(EXP[k].wa));
                chk(dbg_wr_data == EXP[k].wd, {tag, " wdata"}, dbg_wr_data, EXP[k].wd);
            end
            @(posedge clk);
            @(negedge clk);
        end
        // R2: step after the last table entry
        chk(dbg_pc == 32'd88, "R2 sequential step", dbg_pc, 32'd88);
        // R1: reset in the middle of execution
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk(dbg_pc == 0, "R1 mid-run reset pc", dbg_pc, 0);
        chk(dbg_wr_en == 1'b0, "R1 mid-run reset write enable", 32'(dbg_wr_en), 0);
        rst = 1'b0;
        #1;
        chk(dbg_pc == 0 && dbg_wr_en && dbg_wr_data == 32'd5, "R1 restart from 0", dbg_wr_data, 32'd5);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule